// File: doc/BRIEF.md
# Raster Scroll Address Register Unit

This block holds the two scroll address registers of a tile-based raster video generator. A staging register (T) is loaded by processor writes to three register slots: control, scroll and address. A working register (V) is the address the renderer walks while drawing. An external dot and line counter tells the block when to step V down by one row, and when to reload its horizontal or vertical fields from T.

Each processor write takes two pixel clocks inside the block. When the phase input says the clocks are aligned, the first of those clocks sees the stale open-bus byte instead of the real data. T is written with that stale byte, and a dot event in the same clock copies the same stale fields. On the second clock T is rewritten with the real data. V keeps whatever it copied until its next reload. A write that lands on the horizontal reload dot can therefore leave a wrong column or nametable in V while T looks correct.

Both registers use the same 15-bit layout. Bits 4:0 hold coarse X, bits 9:5 hold coarse Y, bit 10 holds the horizontal nametable select, bit 11 holds the vertical nametable select, and bits 14:12 hold fine Y.

Top module: `scroll_addr_unit`

## Requirements
- R1: After reset, t_addr, v_addr, fine_x and wr_toggle are all zero.
- R2: A control write (wr_sel=0) loads T[11:10] from data[1:0] and leaves wr_toggle unchanged.
- R3: Scroll writes (wr_sel=1) behave as follows. With wr_toggle=0, T[4:0] takes data[7:3] and fine_x takes data[2:0]. With wr_toggle=1, T[9:5] takes data[7:3] and T[14:12] takes data[2:0]. Each scroll write inverts wr_toggle when it completes.
- R4: Address writes (wr_sel=2) behave as follows. With wr_toggle=0, T[13:8] takes data[5:0] and T[14] is cleared. With wr_toggle=1, T[7:0] takes data and V is loaded with the whole new T. Each address write inverts wr_toggle when it completes. wr_sel=3 changes nothing.
- R5: An accepted strobe occupies the strobe clock and the clock after it, and its result is visible after the second edge. A strobe raised during that second clock is ignored.
- R6: On dot 256 of a visible or pre-render line with rendering on, V steps one row. Fine Y increments if it is below 7. Otherwise fine Y becomes 0 and coarse Y steps: 29 goes to 0 and inverts V[11], 30 and 31 go to 0 without touching V[11], and any other value increments.
- R7: On dot 257 of a visible or pre-render line with rendering on, V[4:0] and V[10] are copied from T.
- R8: On dots 280 to 304 of the pre-render line with rendering on, V[9:5], V[11] and V[14:12] are copied from T.
- R9: With render_en low, V changes only through the completion of a second address write.
- R10: With phase_sel=1, a write starting on a reload dot makes the copied V fields take values derived from open_bus, while T ends with the intended data. With phase_sel=0, the same write copies the intended data into V.
- R11: When a second address write completes on a dot-event clock, the load from T wins over the render event.
- R12: T and fine_x change only in the two clocks of a write. wr_toggle changes only on a write's second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| render_en | input | 1 | Rendering enabled |
| visible_line | input | 1 | Current line is visible |
| prerender_line | input | 1 | Current line is the pre-render line |
| dot | input | DOT_W | Current dot within the line |
| wr_stb | input | 1 | Processor write starts this clock |
| wr_sel | input | 2 | Register slot: 0 control, 1 scroll, 2 address, 3 none |
| wr_data | input | 8 | Data the processor intends to write |
| open_bus | input | 8 | Stale bus byte seen before data settles |
| phase_sel | input | 1 | 1: the first write clock sees open_bus |
| t_addr | output | 15 | Staging register T |
| v_addr | output | 15 | Working register V |
| fine_x | output | 3 | Fine horizontal scroll |
| wr_toggle | output | 1 | First/second write flag |

## Verification
Two functions can fall in the same clock. The first is a processor write starting on the horizontal or vertical reload dot. The second is a second address write completing on the row-step dot. The bench starts writes on dots 256 and 257, with phase_sel set and cleared and with open_bus differing from the data. It then compares V and T separately: V must hold the open-bus fields only in the aligned case, and T must always hold the intended fields. Random traffic concentrated on the event dots is also compared cycle by cycle against a bench model.

// File: rtl/scroll_pkg.sv
`timescale 1ns/1ps
package scroll_pkg;
  localparam int ADDR_W = 15;
  typedef logic [ADDR_W-1:0] vaddr_t;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_SCROLL = 2'd1,
    REG_ADDR   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [2:0] fx;
    vaddr_t     t;
  } wr_res_t;

  // Field effect of one write byte on T and fine X.
  function automatic wr_res_t apply_write(vaddr_t t, logic [2:0] fx,
                                          reg_sel_e sel, logic [7:0] d,
                                          logic second);
    wr_res_t r;
    r.t  = t;
    r.fx = fx;
    case (sel)
      REG_CTRL: r.t[11:10] = d[1:0];
      REG_SCROLL: begin
        if (!second) begin
          r.t[4:0] = d[7:3];
          r.fx     = d[2:0];
        end else begin
          r.t[9:5]   = d[7:3];
          r.t[14:12] = d[2:0];
        end
      end
      REG_ADDR: begin
        if (!second) begin
          r.t[13:8] = d[5:0];
          r.t[14]   = 1'b0;
        end else begin
          r.t[7:0] = d;
        end
      end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sau_write_seq.sv
`timescale 1ns/1ps
module sau_write_seq
  import scroll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [7:0] open_bus,
  input  logic       phase_sel,
  output logic       busy,
  output logic       active,
  output reg_sel_e   sel_eff,
  output logic [7:0] bus_eff
);
  logic       busy_q;
  reg_sel_e   sel_q;
  logic [7:0] data_q;
  logic       accept;

  assign accept  = wr_stb && !busy_q;
  assign busy    = busy_q;
  assign active  = accept || busy_q;
  assign sel_eff = busy_q ? sel_q : reg_sel_e'(wr_sel);
  // First clock: bus may still hold the stale byte; second: held real data.
  assign bus_eff = busy_q ? data_q : (phase_sel ? open_bus : wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= REG_NONE;
      data_q <= '0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        sel_q  <= reg_sel_e'(wr_sel);
        data_q <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sau_render_ctl.sv
`timescale 1ns/1ps
module sau_render_ctl #(
  parameter int DOT_W       = 9,
  parameter int VINC_DOT    = 256,
  parameter int HCOPY_DOT   = 257,
  parameter int VCOPY_FIRST = 280,
  parameter int VCOPY_LAST  = 304
) (
  input  logic             render_en,
  input  logic             visible_line,
  input  logic             prerender_line,
  input  logic [DOT_W-1:0] dot,
  output logic             do_vinc,
  output logic             do_hcopy,
  output logic             do_vcopy
);
  localparam logic [DOT_W-1:0] D_VINC  = DOT_W'(VINC_DOT);
  localparam logic [DOT_W-1:0] D_HCOPY = DOT_W'(HCOPY_DOT);
  localparam logic [DOT_W-1:0] D_VLO   = DOT_W'(VCOPY_FIRST);
  localparam logic [DOT_W-1:0] D_VHI   = DOT_W'(VCOPY_LAST);

  logic live;
  assign live     = render_en && (visible_line || prerender_line);
  assign do_vinc  = live && (dot == D_VINC);
  assign do_hcopy = live && (dot == D_HCOPY);
  assign do_vcopy = render_en && prerender_line && (dot >= D_VLO) && (dot <= D_VHI);
endmodule

// File: rtl/sau_vinc.sv
`timescale 1ns/1ps
module sau_vinc
  import scroll_pkg::*;
#(
  parameter int ROW_LAST = 29
) (
  input  vaddr_t v_in,
  output vaddr_t v_out
);
  localparam logic [4:0] CY_LAST = 5'(ROW_LAST);

  always_comb begin
    v_out = v_in;
    if (v_in[14:12] != 3'd7) begin
      v_out[14:12] = v_in[14:12] + 3'd1;
    end else begin
      v_out[14:12] = 3'd0;
      if (v_in[9:5] == CY_LAST) begin
        v_out[9:5] = 5'd0;
        v_out[11]  = ~v_in[11];
      end else if (v_in[9:5] > CY_LAST) begin
        v_out[9:5] = 5'd0;
      end else begin
        v_out[9:5] = v_in[9:5] + 5'd1;
      end
    end
  end
endmodule

// File: rtl/scroll_addr_unit.sv
`timescale 1ns/1ps
module scroll_addr_unit
  import scroll_pkg::*;
#(
  parameter int DOT_W       = 9,
  parameter int VINC_DOT    = 256,
  parameter int HCOPY_DOT   = 257,
  parameter int VCOPY_FIRST = 280,
  parameter int VCOPY_LAST  = 304,
  parameter int ROW_LAST    = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             render_en,
  input  logic             visible_line,
  input  logic             prerender_line,
  input  logic [DOT_W-1:0] dot,
  input  logic             wr_stb,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       open_bus,
  input  logic             phase_sel,
  output logic [14:0]      t_addr,
  output logic [14:0]      v_addr,
  output logic [2:0]       fine_x,
  output logic             wr_toggle
);
  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic       wr_busy, wr_active;
  reg_sel_e   sel_eff;
  logic [7:0] bus_eff;

  sau_write_seq u_wseq (
    .clk(clk), .rst_n(rst_s), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_data(wr_data), .open_bus(open_bus), .phase_sel(phase_sel),
    .busy(wr_busy), .active(wr_active), .sel_eff(sel_eff), .bus_eff(bus_eff)
  );

  logic do_vinc, do_hcopy, do_vcopy;

  sau_render_ctl #(
    .DOT_W(DOT_W), .VINC_DOT(VINC_DOT), .HCOPY_DOT(HCOPY_DOT),
    .VCOPY_FIRST(VCOPY_FIRST), .VCOPY_LAST(VCOPY_LAST)
  ) u_rctl (
    .render_en(render_en), .visible_line(visible_line),
    .prerender_line(prerender_line), .dot(dot),
    .do_vinc(do_vinc), .do_hcopy(do_hcopy), .do_vcopy(do_vcopy)
  );

  vaddr_t     t_q, v_q, v_stepped, t_live, v_n;
  logic [2:0] fx_q, fx_live;
  logic       tog_q, tog_n;
  wr_res_t    wres;

  sau_vinc #(.ROW_LAST(ROW_LAST)) u_vinc (.v_in(v_q), .v_out(v_stepped));

  // Next-state: T is transparent during a write so reloads see the bus value.
  always_comb begin
    wres    = apply_write(t_q, fx_q, sel_eff, bus_eff, tog_q);
    t_live  = wr_active ? wres.t  : t_q;
    fx_live = wr_active ? wres.fx : fx_q;

    v_n = v_q;
    if (wr_busy && sel_eff == REG_ADDR && tog_q) begin
      v_n = t_live;
    end else begin
      if (do_vinc) v_n = v_stepped;
      if (do_hcopy) begin
        v_n[4:0] = t_live[4:0];
        v_n[10]  = t_live[10];
      end
      if (do_vcopy) begin
        v_n[9:5]   = t_live[9:5];
        v_n[11]    = t_live[11];
        v_n[14:12] = t_live[14:12];
      end
    end

    tog_n = tog_q;
    if (wr_busy && (sel_eff == REG_SCROLL || sel_eff == REG_ADDR)) tog_n = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      t_q   <= '0;
      fx_q  <= '0;
      v_q   <= '0;
      tog_q <= 1'b0;
    end else begin
      if (wr_active) begin
        t_q  <= t_live;
        fx_q <= fx_live;
      end
      if (wr_busy) tog_q <= tog_n;
      v_q <= v_n;
    end
  end

  assign t_addr    = t_q;
  assign v_addr    = v_q;
  assign fine_x    = fx_q;
  assign wr_toggle = tog_q;
endmodule

// File: rtl/sau_checker.sv
`timescale 1ns/1ps
module sau_checker #(
  parameter int DOT_W     = 9,
  parameter int VINC_DOT  = 256,
  parameter int HCOPY_DOT = 257
) (
  input logic             clk,
  input logic             rst_n,
  input logic             render_en,
  input logic             visible_line,
  input logic             prerender_line,
  input logic [DOT_W-1:0] dot,
  input logic             wr_stb,
  input logic             wr_busy,
  input logic [14:0]      t_addr,
  input logic [14:0]      v_addr,
  input logic [2:0]       fine_x,
  input logic             wr_toggle
);
  // R5: a write holds the sequencer for exactly one extra clock
  a_r5_busy_one: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |=> !wr_busy);

  // R12: no write in progress, no strobe -> T and fine X hold
  a_r12_t_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_busy && !wr_stb) |=> ($stable(t_addr) && $stable(fine_x)));

  // R12: toggle flips only on the completing clock
  a_r12_toggle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_busy |=> $stable(wr_toggle));

  // R9: rendering off and no completing write -> V holds
  a_r9_v_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!render_en && !wr_busy) |=> $stable(v_addr));

  // R7: horizontal reload takes T fields when no write overlaps
  a_r7_hcopy: assert property (@(posedge clk) disable iff (!rst_n)
    (render_en && (visible_line || prerender_line) && dot == DOT_W'(HCOPY_DOT)
     && !wr_busy && !wr_stb)
    |=> (v_addr[4:0] == $past(t_addr[4:0]) && v_addr[10] == $past(t_addr[10])));

  // R6: fine Y step below 7
  a_r6_fine_step: assert property (@(posedge clk) disable iff (!rst_n)
    (render_en && (visible_line || prerender_line) && dot == DOT_W'(VINC_DOT)
     && !wr_busy && v_addr[14:12] != 3'd7)
    |=> (v_addr[14:12] == 3'($past(v_addr[14:12]) + 3'd1)));
endmodule

bind scroll_addr_unit sau_checker #(
  .DOT_W(DOT_W), .VINC_DOT(VINC_DOT), .HCOPY_DOT(HCOPY_DOT)
) chk_i (
  .clk(clk), .rst_n(rst_s), .render_en(render_en), .visible_line(visible_line),
  .prerender_line(prerender_line), .dot(dot), .wr_stb(wr_stb), .wr_busy(wr_busy),
  .t_addr(t_addr), .v_addr(v_addr), .fine_x(fine_x), .wr_toggle(wr_toggle)
);

// File: tb/scroll_addr_unit_tb_top.sv
`timescale 1ns/1ps
module scroll_addr_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       i_ren = 1'b0, i_vis = 1'b0, i_pre = 1'b0;
  logic [8:0] i_dot = '0;
  logic       i_stb = 1'b0;
  logic [1:0] i_sel = 2'd3;
  logic [7:0] i_data = '0, i_ob = '0;
  logic       i_ph = 1'b0;
  logic [14:0] o_t, o_v;
  logic [2:0]  o_fx;
  logic        o_tog;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scroll_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .render_en(i_ren), .visible_line(i_vis),
    .prerender_line(i_pre), .dot(i_dot), .wr_stb(i_stb), .wr_sel(i_sel),
    .wr_data(i_data), .open_bus(i_ob), .phase_sel(i_ph),
    .t_addr(o_t), .v_addr(o_v), .fine_x(o_fx), .wr_toggle(o_tog)
  );

  // ---------------- bench reference model ----------------
  function automatic logic [17:0] tb_apply(logic [14:0] t, logic [2:0] fx,
                                           logic [1:0] s, logic [7:0] d, logic sec);
    logic [14:0] nt = t;
    logic [2:0]  nf = fx;
    if (s == 2'd0) nt[11:10] = d[1:0];
    else if (s == 2'd1) begin
      if (sec) begin nt[9:5] = d[7:3]; nt[14:12] = d[2:0]; end
      else     begin nt[4:0] = d[7:3]; nf = d[2:0]; end
    end else if (s == 2'd2) begin
      if (sec) nt[7:0] = d;
      else     begin nt[13:8] = d[5:0]; nt[14] = 1'b0; end
    end
    return {nf, nt};
  endfunction

  function automatic logic [14:0] tb_vinc(logic [14:0] v);
    logic [14:0] n = v;
    if (v[14:12] < 3'd7) n[14:12] = v[14:12] + 3'd1;
    else begin
      n[14:12] = 3'd0;
      if (v[9:5] == 5'd29) begin n[9:5] = 5'd0; n[11] = ~v[11]; end
      else if (v[9:5] >= 5'd30) n[9:5] = 5'd0;
      else n[9:5] = v[9:5] + 5'd1;
    end
    return n;
  endfunction

  logic [14:0] m_t, m_v;
  logic [2:0]  m_fx;
  logic        m_tog, m_busy;
  logic [1:0]  m_sel;
  logic [7:0]  m_data;

  always @(posedge clk or negedge rst_n) begin
    logic        act;
    logic [1:0]  s;
    logic [7:0]  b;
    logic [17:0] r;
    logic [14:0] vn;
    if (!rst_n) begin
      m_t <= '0; m_v <= '0; m_fx <= '0; m_tog <= 1'b0;
      m_busy <= 1'b0; m_sel <= 2'd3; m_data <= '0;
    end else begin
      act = m_busy || i_stb;
      s   = m_busy ? m_sel : i_sel;
      b   = m_busy ? m_data : (i_ph ? i_ob : i_data);
      r   = act ? tb_apply(m_t, m_fx, s, b, m_tog) : {m_fx, m_t};
      vn  = m_v;
      if (m_busy && s == 2'd2 && m_tog) vn = r[14:0];
      else if (i_ren) begin
        if ((i_vis || i_pre) && i_dot == 9'd256) vn = tb_vinc(m_v);
        if ((i_vis || i_pre) && i_dot == 9'd257) begin vn[4:0] = r[4:0]; vn[10] = r[10]; end
        if (i_pre && i_dot >= 9'd280 && i_dot <= 9'd304) begin
          vn[9:5] = r[9:5]; vn[11] = r[11]; vn[14:12] = r[14:12];
        end
      end
      m_t <= r[14:0]; m_fx <= r[17:15]; m_v <= vn;
      if (m_busy && (s == 2'd1 || s == 2'd2)) m_tog <= ~m_tog;
      m_busy <= !m_busy && i_stb;
      if (!m_busy && i_stb) begin m_sel <= i_sel; m_data <= i_data; end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_model(string tag);
    chk({tag, " T"},   o_t,   m_t);
    chk({tag, " V"},   o_v,   m_v);
    chk({tag, " fx"},  o_fx,  m_fx);
    chk({tag, " tog"}, o_tog, m_tog);
  endtask

  // Drive one clock: inputs set at a falling edge, result visible at the next.
  task automatic cyc(int dot, bit vis, bit pre, bit ren, bit stb, int sel,
                     int data, int ob, bit ph);
    i_dot = 9'(dot); i_vis = vis; i_pre = pre; i_ren = ren; i_stb = stb;
    i_sel = 2'(sel); i_data = 8'(data); i_ob = 8'(ob); i_ph = ph;
    @(negedge clk);
  endtask

  task automatic idle(int dot);
    cyc(dot, 1'b0, 1'b0, 1'b0, 1'b0, 3, 0, 0, 1'b0);
  endtask

  // Complete write (2 clocks), render off, no dot events.
  task automatic wr(int sel, int data);
    cyc(10, 1'b0, 1'b0, 1'b0, 1'b1, sel, data, 8'hA5, 1'b1);
    idle(11);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [14:0] v_keep;
    void'($urandom(32'd1357));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle(0);

    // R1 reset state
    chk("R1 T", o_t, 0); chk("R1 V", o_v, 0);
    chk("R1 fx", o_fx, 0); chk("R1 tog", o_tog, 0);

    // R2 control write
    wr(0, 8'h03);
    chk("R2 T", o_t, 15'h0C00); chk("R2 tog", o_tog, 0);

    // R3 scroll pair
    wr(1, 8'hAD);
    chk("R3 T first", o_t, 15'h0C15); chk("R3 fx", o_fx, 5); chk("R3 tog", o_tog, 1);
    wr(1, 8'h5E);
    chk("R3 T second", o_t, 15'h6D75); chk("R3 tog back", o_tog, 0);

    // R4 address pair
    wr(2, 8'h7F);
    chk("R4 T first", o_t, 15'h3F75); chk("R4 V held", o_v, 0);
    wr(2, 8'h21);
    chk("R4 T second", o_t, 15'h3F21); chk("R4 V load", o_v, 15'h3F21);
    chk("R4 tog", o_tog, 0);
    wr(3, 8'hFF);
    chk("R4 none slot", o_t, 15'h3F21);

    // R5 strobe during second clock ignored
    wr(0, 8'h00);
    cyc(10, 0, 0, 0, 1'b1, 0, 8'h01, 0, 1'b0);
    cyc(11, 0, 0, 0, 1'b1, 0, 8'h02, 0, 1'b0);
    idle(12);
    chk("R5 ignored strobe", o_t[11:10], 1);
    wr(0, 8'h00);

    // R10 collision, aligned phase: scroll first write on dot 257
    cyc(257, 1, 0, 1, 1'b1, 1, 8'h08, 8'hF9, 1'b1);
    cyc(258, 1, 0, 1, 1'b0, 3, 8'h08, 8'hF9, 1'b1);
    chk("R10 aligned V coarseX", o_v[4:0], 31);
    chk("R10 aligned T coarseX", o_t[4:0], 1);
    wr(1, 8'h00);
    // non-aligned phase
    cyc(257, 1, 0, 1, 1'b1, 1, 8'h08, 8'hF9, 1'b0);
    cyc(258, 1, 0, 1, 1'b0, 3, 8'h08, 8'hF9, 1'b0);
    chk("R10 nonaligned V coarseX", o_v[4:0], 1);
    wr(1, 8'h00);
    // control write on dot 257, aligned
    cyc(257, 1, 0, 1, 1'b1, 0, 8'h00, 8'h01, 1'b1);
    cyc(258, 1, 0, 1, 1'b0, 3, 8'h00, 8'h01, 1'b1);
    chk("R10 ctrl V nt", o_v[10], 1);
    chk("R10 ctrl T nt", o_t[10], 0);

    // R8 vertical reload on pre-render line, then R6 wrap at 29
    wr(1, 8'h00); wr(1, 8'hEF); wr(0, 8'h02);
    cyc(290, 0, 1, 1, 0, 3, 0, 0, 0);
    chk("R8 coarseY", o_v[9:5], 29); chk("R8 fineY", o_v[14:12], 7);
    chk("R8 nt", o_v[11], 1);
    cyc(256, 1, 0, 1, 0, 3, 0, 0, 0);
    chk("R6 wrap29 coarseY", o_v[9:5], 0); chk("R6 wrap29 fineY", o_v[14:12], 0);
    chk("R6 wrap29 nt toggled", o_v[11], 0);
    // R6 wrap at 30 without toggle
    wr(1, 8'h00); wr(1, 8'hF7);
    cyc(300, 0, 1, 1, 0, 3, 0, 0, 0);
    cyc(256, 1, 0, 1, 0, 3, 0, 0, 0);
    chk("R6 wrap30 coarseY", o_v[9:5], 0); chk("R6 wrap30 nt kept", o_v[11], 1);
    cyc(256, 1, 0, 1, 0, 3, 0, 0, 0);
    chk("R6 fine step", o_v[14:12], 1);

    // R9 render off: event dots do nothing
    v_keep = o_v;
    cyc(256, 1, 0, 0, 0, 3, 0, 0, 0);
    cyc(257, 1, 0, 0, 0, 3, 0, 0, 0);
    cyc(290, 0, 1, 0, 0, 3, 0, 0, 0);
    chk("R9 V held", o_v, v_keep);

    // R11 address completion wins over row step
    wr(2, 8'h01);
    cyc(255, 1, 0, 1, 1'b1, 2, 8'h23, 8'hFF, 1'b1);
    cyc(256, 1, 0, 1, 1'b0, 3, 0, 0, 1'b1);
    chk("R11 V load wins", o_v, 15'h0123);

    // R12 random traffic concentrated on event dots vs model
    chk_model("R12 pre-random");
    for (int k = 0; k < 4000; k++) begin
      int dsel = $urandom_range(0, 7);
      int d;
      case (dsel)
        0: d = 255; 1: d = 256; 2: d = 257; 3: d = 258;
        4: d = 280; 5: d = 304; 6: d = 292;
        default: d = $urandom_range(0, 340);
      endcase
      cyc(d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 9) < 8), ($urandom_range(0, 9) < 3),
          $urandom_range(0, 3), $urandom_range(0, 255),
          $urandom_range(0, 255), 1'($urandom_range(0, 1)));
      chk_model("R12 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule